// File: doc/BRIEF.md
# Low-power mode sequencer with port wake-up

This block sets the power state of a small 8-bit controller core. Software writes a two-bit power-control value. One bit asks for idle: the CPU clock stops while the timers, serial logic and interrupt logic keep their clock. The other bit asks for power-down: the oscillator itself is switched off. The instruction that writes the value is the last one the CPU runs before the mode takes effect.

Several events end a mode:
- In idle, an interrupt request ends the mode when the global enable is set.
- In either mode, a high-to-low transition ends the mode. It can come on any pin of a monitored 8-bit port, or on the serial clock or serial data lines.
- In either mode, a qualified reset ends the mode.

A pin wake while interrupts are enabled raises a one-cycle request. That request sends the CPU to the fixed service entry 0x0023. With interrupts disabled there is no request, and the CPU simply resumes at the next instruction.

A wake flag records every wake. The CPU's service-routine entry strobe clears it. The reset pin counts as a reset only after it stays high for a set number of consecutive clocks. A qualified reset clears the power bits and the flag.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: The power-control write takes `wr_data[0]` as the idle request and `wr_data[1]` as the power-down request. If both bits are 1, only power-down is entered. Writing 00 leaves the core running.
- R2: While running, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 1. In idle they are 0, 1 and 1.
- R3: In power-down, `cpu_clk_en`, `per_clk_en` and `osc_en` are all 0. `osc_en` returns to 1 only when a pin wake is caught or `rst_pin` is high.
- R4: In idle, a request on any `irq_req` bit with `gie`=1 ends idle on the next clock edge. That wake sets `wake_flag` and gives no `vec_req`. With `gie`=0 the request has no effect.
- R5: In idle, a falling edge on any monitored line ends idle on the third clock edge. The monitored lines are the 8 `port_pin` bits, `ser_clk` and `ser_dat`. `vec_req` is then a one-cycle pulse if `gie`=1, and stays 0 if `gie`=0.
- R6: In power-down, a falling edge on a monitored line sets `osc_en` at once, without waiting for a clock. Power-down ends on the third clock edge after the clock restarts. `vec_req` pulses for one cycle only if `gie` is 1 at that edge.
- R7: Interrupt requests do not end power-down.
- R8: `wake_flag` is set by every wake from either mode. It is cleared by `isr_ack`, and otherwise stays set. If a wake and `isr_ack` fall in the same cycle, the flag is set.
- R9: `core_rst` asserts on the 26th clock edge after `rst_pin` goes high. This is two synchronizer stages followed by 24 consecutive high samples. A low sample restarts the count. `core_rst` drops on the third edge after `rst_pin` goes low.
- R10: While `core_rst` is high, the power bits, `wake_flag` and `vec_req` are cleared, so the core runs once `core_rst` is released. `osc_en` is 1 whenever `rst_pin` is high.
- R11: A falling edge on a monitored line while the core is running has no effect on `wake_flag`, `vec_req` or the clock enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock (stops while `osc_en` is 0) |
| wr_en | input | 1 | Power-control write strobe |
| wr_data | input | 2 | Bit 0 idle request, bit 1 power-down request |
| irq_req | input | IRQ_W | Interrupt requests, already individually enabled |
| gie | input | 1 | Global interrupt enable |
| port_pin | input | PORT_W | Monitored general-purpose port pins |
| ser_clk | input | 1 | Serial clock line, monitored for falling edges |
| ser_dat | input | 1 | Serial data line, monitored for falling edges |
| rst_pin | input | 1 | Raw reset pin, active high |
| isr_ack | input | 1 | Strobe from the CPU on service-routine entry |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| vec_req | output | 1 | One-cycle request to vector to 0x0023 |
| wake_flag | output | 1 | Wake indication flag |
| core_rst | output | 1 | Qualified reset to the core |

## Verification
The internal state that matters is the pair of power bits, the wake latches and the reset counter. Each one shows at the ports within a known number of clocks:
- A wrong power bit shows at the clock enables on the edge after the write.
- A missed or spurious pin wake shows at `wake_flag` and `vec_req` exactly three edges after the edge.
- A latch that fails to catch an edge in power-down leaves `osc_en` low with no clock, so the core stays asleep for good.
- A counter that fails to restart shows as `core_rst` rising before the 26th edge after the pin last went high.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int PORT_W  = 8,
  parameter int IRQ_W   = 5,
  parameter int RST_CYC = 24
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [1:0]        wr_data,
  input  logic [IRQ_W-1:0]  irq_req,
  input  logic              gie,
  input  logic [PORT_W-1:0] port_pin,
  input  logic              ser_clk,
  input  logic              ser_dat,
  input  logic              rst_pin,
  input  logic              isr_ack,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              vec_req,
  output logic              wake_flag,
  output logic              core_rst
);
  localparam int MON_W = PORT_W + 2;
  localparam int CNT_W = $clog2(RST_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(RST_CYC);

  logic [MON_W-1:0] mon, ms1, ms2, ms3, alat;
  logic [1:0]       rs, ws;
  logic [CNT_W-1:0] rcnt;
  logic             idl_q, pd_q, lclr_q;
  logic             fall_any, irq_any, idle_wake, pd_wake;

  assign mon = {ser_dat, ser_clk, port_pin};

  always_ff @(posedge clk) begin
    ms1 <= mon;
    ms2 <= ms1;
    ms3 <= ms2;
    rs  <= {rs[0], rst_pin};
    ws  <= {ws[0], |alat};
  end

  always_ff @(posedge clk) begin
    if (!rs[1])
      rcnt <= '0;
    else if (rcnt != CNT_TOP)
      rcnt <= rcnt + 1'b1;
  end

  assign core_rst = (rcnt == CNT_TOP);

  for (genvar g = 0; g < MON_W; g++) begin : g_wlat
    logic hit;
    always_ff @(negedge mon[g] or posedge lclr_q) begin
      if (lclr_q) hit <= 1'b0;
      else        hit <= pd_q;
    end
    assign alat[g] = hit;
  end

  assign fall_any  = |(ms3 & ~ms2);
  assign irq_any   = gie & (|irq_req);
  assign idle_wake = idl_q & (irq_any | fall_any);
  assign pd_wake   = pd_q & ws[1];

  always_ff @(posedge clk) begin
    if (core_rst) begin
      idl_q     <= 1'b0;
      pd_q      <= 1'b0;
      wake_flag <= 1'b0;
      vec_req   <= 1'b0;
      lclr_q    <= 1'b1;
    end else begin
      vec_req <= 1'b0;
      lclr_q  <= 1'b0;
      if (pd_wake) begin
        pd_q      <= 1'b0;
        wake_flag <= 1'b1;
        vec_req   <= gie;
        lclr_q    <= 1'b1;
      end else if (idle_wake) begin
        idl_q     <= 1'b0;
        wake_flag <= 1'b1;
        vec_req   <= fall_any & gie;
      end else begin
        if (wr_en) begin
          pd_q  <= wr_data[1];
          idl_q <= wr_data[0] & ~wr_data[1];
        end
        if (isr_ack) wake_flag <= 1'b0;
      end
    end
  end

  assign cpu_clk_en = ~idl_q & ~pd_q;
  assign per_clk_en = ~pd_q;
  assign osc_en     = ~pd_q | (|alat) | rst_pin;
endmodule

module pwr_mode_ctrl_chk #(
  parameter int PORT_W = 8,
  parameter int IRQ_W  = 5
) (
  input logic              clk,
  input logic [IRQ_W-1:0]  irq_req,
  input logic              gie,
  input logic              cpu_clk_en,
  input logic              per_clk_en,
  input logic              vec_req,
  input logic              wake_flag,
  input logic              core_rst
);
  logic seen_rst = 1'b0;
  always_ff @(posedge clk) if (core_rst) seen_rst <= 1'b1;

  assert_irq_ends_idle_R4: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    (!cpu_clk_en && per_clk_en && gie && (|irq_req)) |=> cpu_clk_en);

  assert_vec_single_R5: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    vec_req |=> !vec_req);

  assert_vec_needs_gie_R6: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    vec_req |-> $past(gie));

  assert_wake_sets_flag_R8: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    ($rose(cpu_clk_en) && !$past(core_rst)) |-> wake_flag);

  assert_reset_clears_R10: assert property (@(posedge clk) disable iff (core_rst || !seen_rst)
    $past(core_rst) |-> (cpu_clk_en && !wake_flag && !vec_req));
endmodule

bind pwr_mode_ctrl pwr_mode_ctrl_chk #(.PORT_W(PORT_W), .IRQ_W(IRQ_W)) u_chk (
  .clk(clk), .irq_req(irq_req), .gie(gie), .cpu_clk_en(cpu_clk_en),
  .per_clk_en(per_clk_en), .vec_req(vec_req), .wake_flag(wake_flag),
  .core_rst(core_rst));

// File: tb/pwr_mode_ctrl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb;
  logic rclk = 1'b0, gate = 1'b0, clk;
  logic wr_en = 1'b0, gie = 1'b0, ser_clk = 1'b1, ser_dat = 1'b1, rst_pin = 1'b0, isr_ack = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [4:0] irq_req = '0;
  logic [7:0] port_pin = 8'hFF;
  logic cpu_clk_en, per_clk_en, osc_en, vec_req, wake_flag, core_rst;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 rclk = ~rclk;
  always @(negedge rclk) gate = osc_en;
  assign clk = rclk & gate;

  pwr_mode_ctrl u_dut (.*);

  localparam logic [4:0] TBL [4] = '{5'b00_111, 5'b01_011, 5'b10_000, 5'b11_000};

  task automatic step(); @(negedge rclk); #1; endtask

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] clks(); return {5'b0, cpu_clk_en, per_clk_en, osc_en}; endfunction

  task automatic do_reset();
    rst_pin = 1'b1; #1;
    chk("R10 osc_en forced by rst_pin", {7'b0, osc_en}, 8'd1);
    repeat (30) step();
    chk("R10 core_rst held", {7'b0, core_rst}, 8'd1);
    rst_pin = 1'b0;
    repeat (4) step();
  endtask

  task automatic enter(logic [1:0] d);
    wr_en = 1'b1; wr_data = d; step(); wr_en = 1'b0;
  endtask

  task automatic ack();
    isr_ack = 1'b1; step(); isr_ack = 1'b0; step();
  endtask

  initial begin
    repeat (4) step();
    do_reset();
    chk("R10 reset clocks", clks(), 8'h07);
    chk("R10 reset flag/vec/rst", {5'b0, wake_flag, vec_req, core_rst}, 8'h00);

    foreach (TBL[i]) begin
      enter(TBL[i][4:3]);
      chk($sformatf("R1 R2 R3 write %b", TBL[i][4:3]), clks(), {5'b0, TBL[i][2:0]});
      do_reset();
    end

    rst_pin = 1'b1;
    repeat (25) step();
    chk("R9 no reset at edge 25", {7'b0, core_rst}, 8'd0);
    step();
    chk("R9 reset at edge 26", {7'b0, core_rst}, 8'd1);
    rst_pin = 1'b0;
    step(); step();
    chk("R9 still reset 2 edges after drop", {7'b0, core_rst}, 8'd1);
    step();
    chk("R9 released 3 edges after drop", {7'b0, core_rst}, 8'd0);

    rst_pin = 1'b1;
    repeat (20) step();
    rst_pin = 1'b0; step(); rst_pin = 1'b1;
    repeat (10) step();
    chk("R9 count restarted", {7'b0, core_rst}, 8'd0);
    repeat (15) step();
    chk("R9 restart edge 25", {7'b0, core_rst}, 8'd0);
    step();
    chk("R9 restart edge 26", {7'b0, core_rst}, 8'd1);
    rst_pin = 1'b0;
    repeat (4) step();

    enter(2'b01);
    gie = 1'b0; irq_req = 5'b00100;
    repeat (3) step();
    chk("R4 irq with gie=0 ignored", clks(), 8'h03);
    gie = 1'b1; step();
    chk("R4 idle irq wake clocks", clks(), 8'h07);
    chk("R4 idle irq wake flag/vec", {6'b0, wake_flag, vec_req}, 8'h02);
    irq_req = '0;
    ack();
    chk("R8 isr_ack clears flag", {7'b0, wake_flag}, 8'd0);

    port_pin[3] = 1'b0;
    repeat (4) step();
    chk("R11 running edge ignored", {4'b0, cpu_clk_en, per_clk_en, wake_flag, vec_req}, 8'h0C);
    port_pin[3] = 1'b1; repeat (3) step();

    enter(2'b01);
    port_pin[5] = 1'b0;
    step(); step();
    chk("R5 still idle at edge 2", clks(), 8'h03);
    step();
    chk("R5 pin wake edge 3", {4'b0, cpu_clk_en, per_clk_en, wake_flag, vec_req}, 8'h0F);
    step();
    chk("R5 vec one cycle", {7'b0, vec_req}, 8'd0);
    port_pin[5] = 1'b1; repeat (3) step();
    ack();

    enter(2'b01);
    gie = 1'b0; ser_clk = 1'b0;
    repeat (3) step();
    chk("R5 serial clk wake gie=0", {4'b0, cpu_clk_en, per_clk_en, wake_flag, vec_req}, 8'h0E);
    repeat (5) step();
    chk("R8 flag stays without ack", {7'b0, wake_flag}, 8'd1);
    ser_clk = 1'b1; repeat (3) step();
    ack();

    enter(2'b01);
    gie = 1'b1; irq_req = 5'b00001; isr_ack = 1'b1;
    step(); isr_ack = 1'b0; irq_req = '0;
    chk("R8 set wins over ack", {7'b0, wake_flag}, 8'd1);
    ack();

    enter(2'b10);
    chk("R3 power-down clocks", clks(), 8'h00);
    irq_req = 5'b10000;
    repeat (5) step();
    chk("R7 irq ignored in power-down", clks(), 8'h00);
    irq_req = '0;
    port_pin[0] = 1'b0; #1;
    chk("R6 osc_en rises at once", {7'b0, osc_en}, 8'd1);
    step(); step(); step();
    chk("R6 still power-down at edge 2", {7'b0, per_clk_en}, 8'd0);
    step();
    chk("R6 pd wake edge 3", {4'b0, cpu_clk_en, per_clk_en, wake_flag, vec_req}, 8'h0F);
    step();
    chk("R6 vec one cycle", {7'b0, vec_req}, 8'd0);
    port_pin[0] = 1'b1; repeat (3) step();
    ack();

    enter(2'b11);
    gie = 1'b0; ser_dat = 1'b0;
    repeat (4) step();
    chk("R6 serial dat pd wake gie=0", {4'b0, cpu_clk_en, per_clk_en, wake_flag, vec_req}, 8'h0E);
    ser_dat = 1'b1; repeat (3) step();

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule